// File: doc/BRIEF.md
# GPIO Pin Drive Resolver

This block works out the logic level seen on each of a bank of bidirectional general-purpose pins. Every pin can be driven by three sources: the block's own output stage, an external agent, and an internal pull resistor. The block holds a small write-only configuration register file: output value, output enable, polarity, open-drain mode, pull-up, pull-down, input mask, and two pad settings that are kept but not interpreted. From these and the external drive vectors it produces the resolved level of every pin, flags for pins that float without a pull, flags for pins driven to opposite levels from two sides, and the value of the input-data view.

Polarity acts on both paths. It inverts the level the block drives, and it inverts the masked pin level that forms the input-data value. An open-drain pin drives only low levels. When it would drive a high level it releases the pin instead. Set and clear aliases let software change single bits of the output value and output enable without a read-modify-write. All results are registered. They follow a configuration or external-input change after one clock.

Top module: `gpio_res`

## Requirements
- R1: After reset, output value, output enable, polarity, open-drain and input mask are all zero. Pull-up, pull-down, slew and drive-strength take the values of the parameters RST_PU, RST_PD, RST_SLEW and RST_DRV.
- R2: When a pin's output enable is 1, the block drives that pin to (output value XOR polarity).
- R3: A pin whose open-drain bit is 1 is driven only when its level would be low. At a high level the pin is released and resolves as an undriven pin.
- R4: When the block and an external source both drive a pin to opposite levels, that pin's conflict flag is 1 and the pin resolves high (the OR of both levels). Otherwise the flag is 0.
- R5: An undriven pin with pull-up enabled resolves high. This holds even when pull-down is also enabled. An undriven pin with only pull-down enabled resolves low.
- R6: An undriven pin with neither pull enabled has its undefined flag set and reads low. No other pin has the flag set.
- R7: The input-data output equals (resolved level AND input mask) XOR polarity, bit by bit.
- R8: Writes to the input-data address 0x24 and to unmapped addresses change no register and no output.
- R9: A write to 0x68 ORs the data into the output value. A write to 0x6C clears the output-value bits where the data is 1.
- R10: A write to 0x70 ORs the data into the output enable. A write to 0x74 clears the output-enable bits where the data is 1.
- R11: The resolved level, undefined, conflict and input-data outputs follow an external-input change after one clock edge. They follow a register write after two edges: one to store the write, one to register the result.
- R12: The slew and drive-strength registers (addresses 0x1C and 0x20) only store the written value and present it on their outputs.

Register map (byte addresses): 0x00 output value, 0x04 output enable, 0x08 polarity, 0x0C open-drain, 0x10 pull-up, 0x14 pull-down, 0x18 input mask, 0x1C slew, 0x20 drive strength, 0x24 input data (writes ignored), and the aliases 0x68–0x74.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | NPINS | Write data |
| ext_drv_i | input | NPINS | Per pin: 1 when an external source drives the pin |
| ext_lvl_i | input | NPINS | Per pin: level of the external source |
| pin_lvl_o | output | NPINS | Resolved pin levels |
| pin_undef_o | output | NPINS | Per pin: floating with no pull |
| pin_conflict_o | output | NPINS | Per pin: opposite drivers |
| din_o | output | NPINS | Input-data value |
| slew_o | output | NPINS | Stored slew setting |
| drive_o | output | NPINS | Stored drive-strength setting |

## Verification
The assertions assume that the external drive vectors and the write port are synchronous to the clock, and that wr_addr and wr_data are known whenever wr_en is high. With those assumptions, the post-edge register values follow from the pre-edge inputs. The stimulus changes every input only on the falling clock edge. It picks write addresses from the mapped set, the input-data address and one unmapped address, so every decode path is exercised without any input changing at a sampling edge.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_DOUT     = 8'h00;
  localparam logic [ADDR_W-1:0] A_OE       = 8'h04;
  localparam logic [ADDR_W-1:0] A_POL      = 8'h08;
  localparam logic [ADDR_W-1:0] A_ODRN     = 8'h0C;
  localparam logic [ADDR_W-1:0] A_PU       = 8'h10;
  localparam logic [ADDR_W-1:0] A_PD       = 8'h14;
  localparam logic [ADDR_W-1:0] A_IEM      = 8'h18;
  localparam logic [ADDR_W-1:0] A_SLEW     = 8'h1C;
  localparam logic [ADDR_W-1:0] A_DRV      = 8'h20;
  localparam logic [ADDR_W-1:0] A_DIN      = 8'h24;
  localparam logic [ADDR_W-1:0] A_DOUT_SET = 8'h68;
  localparam logic [ADDR_W-1:0] A_DOUT_CLR = 8'h6C;
  localparam logic [ADDR_W-1:0] A_OE_SET   = 8'h70;
  localparam logic [ADDR_W-1:0] A_OE_CLR   = 8'h74;
endpackage

// File: rtl/gpio_res_regs.sv
module gpio_res_regs
  import gpio_res_pkg::*;
#(
  parameter int               NPINS    = 32,
  parameter logic [NPINS-1:0] RST_PU   = '0,
  parameter logic [NPINS-1:0] RST_PD   = '0,
  parameter logic [NPINS-1:0] RST_SLEW = '0,
  parameter logic [NPINS-1:0] RST_DRV  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  oe_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  odrn_q,
  output logic [NPINS-1:0]  pu_q,
  output logic [NPINS-1:0]  pd_q,
  output logic [NPINS-1:0]  iem_q,
  output logic [NPINS-1:0]  slew_q,
  output logic [NPINS-1:0]  drv_q
);

  logic [NPINS-1:0] dout_d, oe_d, pol_d, odrn_d, pu_d, pd_d, iem_d, slew_d, drv_d;

  always_comb begin
    dout_d = dout_q;
    oe_d   = oe_q;
    pol_d  = pol_q;
    odrn_d = odrn_q;
    pu_d   = pu_q;
    pd_d   = pd_q;
    iem_d  = iem_q;
    slew_d = slew_q;
    drv_d  = drv_q;
    if (wr_en) begin
      case (wr_addr)
        A_DOUT:     dout_d = wr_data;
        A_OE:       oe_d   = wr_data;
        A_POL:      pol_d  = wr_data;
        A_ODRN:     odrn_d = wr_data;
        A_PU:       pu_d   = wr_data;
        A_PD:       pd_d   = wr_data;
        A_IEM:      iem_d  = wr_data;
        A_SLEW:     slew_d = wr_data;
        A_DRV:      drv_d  = wr_data;
        A_DOUT_SET: dout_d = dout_q | wr_data;
        A_DOUT_CLR: dout_d = dout_q & ~wr_data;
        A_OE_SET:   oe_d   = oe_q | wr_data;
        A_OE_CLR:   oe_d   = oe_q & ~wr_data;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= '0;
      pol_q  <= '0;
      odrn_q <= '0;
      pu_q   <= RST_PU;
      pd_q   <= RST_PD;
      iem_q  <= '0;
      slew_q <= RST_SLEW;
      drv_q  <= RST_DRV;
    end else if (wr_en) begin
      dout_q <= dout_d;
      oe_q   <= oe_d;
      pol_q  <= pol_d;
      odrn_q <= odrn_d;
      pu_q   <= pu_d;
      pd_q   <= pd_d;
      iem_q  <= iem_d;
      slew_q <= slew_d;
      drv_q  <= drv_d;
    end
  end

  // R8: the read-only view address leaves the register file untouched
  assert_din_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DIN) |=> ($stable(dout_q) && $stable(oe_q) &&
      $stable(pol_q) && $stable(odrn_q) && $stable(pu_q) && $stable(pd_q) &&
      $stable(iem_q)));

  assert_dout_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DOUT_SET) |=>
      (((dout_q & $past(wr_data)) == $past(wr_data)) &&
       ((dout_q & ~$past(wr_data)) == ($past(dout_q) & ~$past(wr_data)))));

  assert_dout_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DOUT_CLR) |=>
      (((dout_q & $past(wr_data)) == '0) &&
       ((dout_q & ~$past(wr_data)) == ($past(dout_q) & ~$past(wr_data)))));

  assert_oe_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_OE_SET) |=>
      (((oe_q & $past(wr_data)) == $past(wr_data)) &&
       ((oe_q & ~$past(wr_data)) == ($past(oe_q) & ~$past(wr_data)))));

  assert_oe_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_OE_CLR) |=>
      (((oe_q & $past(wr_data)) == '0) &&
       ((oe_q & ~$past(wr_data)) == ($past(oe_q) & ~$past(wr_data)))));

endmodule

// File: rtl/gpio_res_core.sv
module gpio_res_core #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] dout,
  input  logic [NPINS-1:0] oe,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] odrn,
  input  logic [NPINS-1:0] pu,
  input  logic [NPINS-1:0] pd,
  input  logic [NPINS-1:0] iem,
  input  logic [NPINS-1:0] ext_drv,
  input  logic [NPINS-1:0] ext_lvl,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] undef,
  output logic [NPINS-1:0] conflict,
  output logic [NPINS-1:0] din
);

  logic [NPINS-1:0] int_lvl, int_en, floating;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign int_lvl[i]  = dout[i] ^ pol[i];
    assign int_en[i]   = oe[i] & ~(odrn[i] & int_lvl[i]);
    assign floating[i] = ~(int_en[i] | ext_drv[i]);
    assign conflict[i] = int_en[i] & ext_drv[i] & (int_lvl[i] ^ ext_lvl[i]);
    assign level[i]    = (ext_drv[i] & ext_lvl[i]) |
                         (int_en[i] & int_lvl[i]) |
                         (floating[i] & pu[i]);
    assign undef[i]    = floating[i] & ~(pu[i] | pd[i]);
    assign din[i]      = (level[i] & iem[i]) ^ pol[i];
  end

endmodule

// File: rtl/gpio_res.sv
module gpio_res
  import gpio_res_pkg::*;
#(
  parameter int               NPINS    = 32,
  parameter logic [NPINS-1:0] RST_PU   = '0,
  parameter logic [NPINS-1:0] RST_PD   = '0,
  parameter logic [NPINS-1:0] RST_SLEW = '0,
  parameter logic [NPINS-1:0] RST_DRV  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  input  logic [NPINS-1:0]  ext_drv_i,
  input  logic [NPINS-1:0]  ext_lvl_i,
  output logic [NPINS-1:0]  pin_lvl_o,
  output logic [NPINS-1:0]  pin_undef_o,
  output logic [NPINS-1:0]  pin_conflict_o,
  output logic [NPINS-1:0]  din_o,
  output logic [NPINS-1:0]  slew_o,
  output logic [NPINS-1:0]  drive_o
);

  logic rst_s1_q, rst_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [NPINS-1:0] dout, oe, pol, odrn, pu, pd, iem;

  gpio_res_regs #(
    .NPINS(NPINS), .RST_PU(RST_PU), .RST_PD(RST_PD),
    .RST_SLEW(RST_SLEW), .RST_DRV(RST_DRV)
  ) u_regs (
    .clk(clk), .rst_n(rst_s2_q), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dout_q(dout), .oe_q(oe), .pol_q(pol),
    .odrn_q(odrn), .pu_q(pu), .pd_q(pd), .iem_q(iem),
    .slew_q(slew_o), .drv_q(drive_o)
  );

  logic [NPINS-1:0] lvl_d, undef_d, conf_d, din_d;

  gpio_res_core #(.NPINS(NPINS)) u_core (
    .dout(dout), .oe(oe), .pol(pol), .odrn(odrn), .pu(pu), .pd(pd),
    .iem(iem), .ext_drv(ext_drv_i), .ext_lvl(ext_lvl_i),
    .level(lvl_d), .undef(undef_d), .conflict(conf_d), .din(din_d)
  );

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      pin_lvl_o      <= '0;
      pin_undef_o    <= '0;
      pin_conflict_o <= '0;
      din_o          <= '0;
    end else begin
      pin_lvl_o      <= lvl_d;
      pin_undef_o    <= undef_d;
      pin_conflict_o <= conf_d;
      din_o          <= din_d;
    end
  end

  assert_float_low_R6: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (pin_undef_o & pin_lvl_o) == '0);

  assert_conflict_driven_R4: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (pin_conflict_o & pin_undef_o) == '0);

  assert_conflict_high_R4: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (pin_conflict_o & ~pin_lvl_o) == '0);

  assert_slew_held_R12: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !(wr_en && wr_addr == A_SLEW) |=> $stable(slew_o));

  assert_drive_held_R12: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !(wr_en && wr_addr == A_DRV) |=> $stable(drive_o));

endmodule

// File: tb/gpio_res_tb.sv
module gpio_res_tb;
  localparam int N = 32;
  localparam logic [N-1:0] P_PU   = 32'h0000_000F;
  localparam logic [N-1:0] P_PD   = 32'h0000_00FF;
  localparam logic [N-1:0] P_SLEW = 32'hA5A5_0000;
  localparam logic [N-1:0] P_DRV  = 32'h0000_5A5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [N-1:0] wr_data = '0, ext_drv = '0, ext_lvl = '0;
  logic [N-1:0] pin_lvl, pin_undef, pin_conf, din, slew, drv;

  always #4 clk = ~clk;

  gpio_res #(.NPINS(N), .RST_PU(P_PU), .RST_PD(P_PD),
             .RST_SLEW(P_SLEW), .RST_DRV(P_DRV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_drv_i(ext_drv), .ext_lvl_i(ext_lvl),
    .pin_lvl_o(pin_lvl), .pin_undef_o(pin_undef), .pin_conflict_o(pin_conf),
    .din_o(din), .slew_o(slew), .drive_o(drv)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;

  // behavioural reference state
  logic [N-1:0] m_dout, m_oe, m_pol, m_od, m_pu, m_pd, m_iem, m_slew, m_drv;
  logic [N-1:0] e_lvl, e_und, e_conf, e_din;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dout = '0; m_oe = '0; m_pol = '0; m_od = '0; m_iem = '0;
      m_pu = P_PU; m_pd = P_PD; m_slew = P_SLEW; m_drv = P_DRV;
      e_lvl = '0; e_und = '0; e_conf = '0; e_din = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit li, drives, lv, un, cf;
        li = m_dout[i] ^ m_pol[i];
        drives = m_oe[i] && !(m_od[i] && li);
        un = 0; cf = 0;
        if (ext_drv[i] && drives) begin
          lv = ext_lvl[i] | li;
          cf = (ext_lvl[i] != li);
        end else if (ext_drv[i]) lv = ext_lvl[i];
        else if (drives) lv = li;
        else if (m_pu[i]) lv = 1;
        else if (m_pd[i]) lv = 0;
        else begin lv = 0; un = 1; end
        e_lvl[i] = lv; e_und[i] = un; e_conf[i] = cf;
        e_din[i] = (lv & m_iem[i]) ^ m_pol[i];
      end
      if (wr_en) begin
        case (wr_addr)
          8'h00: m_dout = wr_data;
          8'h04: m_oe   = wr_data;
          8'h08: m_pol  = wr_data;
          8'h0C: m_od   = wr_data;
          8'h10: m_pu   = wr_data;
          8'h14: m_pd   = wr_data;
          8'h18: m_iem  = wr_data;
          8'h1C: m_slew = wr_data;
          8'h20: m_drv  = wr_data;
          8'h68: m_dout = m_dout | wr_data;
          8'h6C: m_dout = m_dout & ~wr_data;
          8'h70: m_oe   = m_oe | wr_data;
          8'h74: m_oe   = m_oe & ~wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input bit we, input logic [7:0] a, input logic [N-1:0] d,
                       input logic [N-1:0] xd, input logic [N-1:0] xl);
    @(negedge clk);
    if (cmp_en) begin
      chk("R2 level", pin_lvl, e_lvl);
      chk("R6 undef", pin_undef, e_und);
      chk("R4 conflict", pin_conf, e_conf);
      chk("R7 din", din, e_din);
      chk("R12 slew", slew, m_slew);
      chk("R12 drive", drv, m_drv);
    end
    wr_en = we; wr_addr = a; wr_data = d; ext_drv = xd; ext_lvl = xl;
  endtask

  task automatic idle();
    drive(1'b0, 8'h00, '0, ext_drv, ext_lvl);
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    drive(1'b1, a, d, ext_drv, ext_lvl);
    idle();
    idle();
  endtask

  logic [N-1:0] s_lvl, s_und, s_conf, s_din;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) idle();
    cmp_en = 1'b1;
    idle();
    // R1 reset state, R5 pulls, R6 floating
    chk("R1 level", pin_lvl, 32'h0000_000F);
    chk("R1 undef", pin_undef, 32'hFFFF_FF00);
    chk("R1 din", din, 32'h0);
    chk("R1 slew", slew, P_SLEW);
    chk("R1 drive", drv, P_DRV);
    chk("R5 pulls", pin_lvl & 32'hFF, 32'h0F);

    wr(8'h18, 32'hFFFF_FFFF);
    chk("R7 mask", din, 32'h0000_000F);
    wr(8'h00, 32'h0003_0000);
    wr(8'h04, 32'h000F_0000);
    chk("R2 driven", pin_lvl & 32'h000F_0000, 32'h0003_0000);
    wr(8'h0C, 32'h0001_0000);
    chk("R3 odrain", pin_lvl & 32'h000F_0000, 32'h0002_0000);
    chk("R3 odrain undef", pin_undef & 32'h000F_0000, 32'h0001_0000);
    wr(8'h08, 32'h0010_0000);
    chk("R7 polarity", din & 32'h0010_0000, 32'h0010_0000);
    chk("R6 float", pin_undef & 32'h0010_0000, 32'h0010_0000);
    drive(1'b0, 8'h00, '0, 32'h0008_0000, 32'h0008_0000);
    idle();
    chk("R11 ext latency", pin_lvl & 32'h0008_0000, 32'h0008_0000);
    chk("R4 conflict", pin_conf, 32'h0008_0000);
    s_lvl = pin_lvl; s_und = pin_undef; s_conf = pin_conf; s_din = din;
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    chk("R8 level", pin_lvl, s_lvl);
    chk("R8 undef", pin_undef, s_und);
    chk("R8 conflict", pin_conf, s_conf);
    chk("R8 din", din, s_din);
    wr(8'h68, 32'h000C_0000);
    chk("R9 set", pin_lvl & 32'h000F_0000, 32'h000E_0000);
    chk("R9 conflict gone", pin_conf, 32'h0);
    wr(8'h6C, 32'h0003_0000);
    chk("R9 clear", pin_lvl & 32'h000F_0000, 32'h000C_0000);
    chk("R3 odrain low", pin_undef & 32'h0001_0000, 32'h0);
    drive(1'b1, 8'h70, 32'h0030_0000, ext_drv, ext_lvl);
    idle();
    chk("R11 write latency", pin_lvl & 32'h0030_0000, 32'h0);
    idle();
    chk("R10 set", pin_lvl & 32'h0030_0000, 32'h0010_0000);
    chk("R10 set undef", pin_undef & 32'h0030_0000, 32'h0);
    wr(8'h74, 32'h000F_0000);
    chk("R10 clear", pin_lvl & 32'h000F_0000, 32'h0008_0000);
    chk("R10 clear undef", pin_undef & 32'h0007_0000, 32'h0007_0000);
    wr(8'h1C, 32'h1234_5678);
    chk("R12 slew store", slew, 32'h1234_5678);

    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      case ($urandom_range(0, 15))
        0: a = 8'h00;  1: a = 8'h04;  2: a = 8'h08;  3: a = 8'h0C;
        4: a = 8'h10;  5: a = 8'h14;  6: a = 8'h18;  7: a = 8'h1C;
        8: a = 8'h20;  9: a = 8'h24;  10: a = 8'h68; 11: a = 8'h6C;
        12: a = 8'h70; 13: a = 8'h74; 14: a = 8'h40; default: a = 8'h00;
      endcase
      drive($urandom_range(0, 1) == 1, a, $urandom(), $urandom(), $urandom());
    end
    idle();
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule